// File: doc/BRIEF.md
# Ping-Pong Packet Transmit Buffer

This block stores outgoing packets for a bulk IN endpoint. It holds two equal halves, and each half holds one maximum-size packet. With the default of 64 bytes per half, the buffer holds 128 bytes. A producer, either the CPU or a DMA engine, pushes bytes into whichever half is currently open for filling. A single commit strobe then freezes those bytes as one packet, records the packet's length and turns filling over to the other half. The producer can therefore build the next packet while the serial engine is still sending the previous one.

The serial side sees a ready flag together with the length of the oldest frozen packet. It steps through that packet one byte at a time. After sending, it either reports that the host accepted the packet, which frees the half, or asks to send the same packet again, which rewinds to byte 0 of that packet. A synchronous clear drops everything the buffer holds. Token, checksum and toggle handling live outside this block.

Top module: `pp_tx_buffer`

## Requirements
- R1: After reset, no packet is ready, `rd_len_o` is 0, `wr_req_o` is 1 and `ovf_o` is 0.
- R2: A commit freezes the bytes written since the previous commit as one packet. `rd_len_o` reports that byte count, from 0 to PKT_BYTES. A commit with no bytes written produces a ready packet of length 0.
- R3: While a half is being filled, writes beyond PKT_BYTES bytes are dropped and `ovf_o` goes to 1. `ovf_o` stays at 1 until a clear. The packet length never exceeds PKT_BYTES.
- R4: A commit hands filling over to the other half. While exactly one packet is pending, `wr_req_o` stays at 1 and new bytes go into a separate packet.
- R5: While both halves hold frozen packets, `wr_req_o` is 0, and both writes and commits are ignored until a half is freed.
- R6: Packets leave in commit order. `rd_ready_o` and `rd_len_o` always describe the oldest pending packet.
- R7: `rd_data_o` shows the byte at the read position of the oldest packet, starting at byte 0. Each `rd_en_i` cycle moves to the next byte. `rd_en_i` has no effect once the position equals the packet length.
- R8: `ack_i` frees the oldest packet's half and moves to the next packet. `ack_i` with nothing ready has no effect. When `ack_i` and `retry_i` arrive together, `ack_i` wins.
- R9: `retry_i` (without `ack_i`) rewinds the read position to byte 0 of the same packet. The packet stays ready and its length is unchanged.
- R10: `clear_i` discards every pending and partly written packet and clears `ovf_o`. On the next cycle the outputs are the same as after reset.
- R11: A byte presented in the same cycle as a commit strobe is discarded. It is not part of either packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all packets and status |
| wr_valid_i | input | 1 | Byte write strobe into the fill half |
| wr_data_i | input | DATA_W | Byte to write |
| commit_i | input | 1 | Freeze the fill half as one packet and switch halves |
| wr_req_o | output | 1 | A half is open for filling (DMA request) |
| ovf_o | output | 1 | Sticky: a byte was dropped because the half was full |
| rd_ready_o | output | 1 | A frozen packet is waiting to be sent |
| rd_len_o | output | $clog2(PKT_BYTES+1) | Length of the oldest packet, 0 when none is ready |
| rd_en_i | input | 1 | Advance to the next byte of the oldest packet |
| rd_data_o | output | DATA_W | Byte at the current read position |
| ack_i | input | 1 | Host accepted the packet: free its half |
| retry_i | input | 1 | Resend: rewind to byte 0 of the same packet |

## Verification
A swapped fill or send index shows up within one cycle. It appears either as a length on `rd_len_o` that belongs to the wrong packet, or as bytes of the newer packet on `rd_data_o`. A lost or duplicated occupancy bit shows up at the next commit or acknowledge. In that case `wr_req_o` stays high while two packets are pending, or `rd_ready_o` drops while one is still waiting. A read pointer that moves on an idle or over-limit cycle is exposed on the very next sampled byte, and the bench compares that byte against a queue model on every clock.

// File: rtl/pp_txbuf_pkg.sv
package pp_txbuf_pkg;

   // Index of one of the two halves.
   typedef logic bank_t;

   localparam int unsigned NBANKS = 2;

   function automatic bank_t other_bank(input bank_t b);
      return ~b;
   endfunction

endpackage

// File: rtl/pp_txbuf_bank.sv
module pp_txbuf_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   // Storage has no reset; its contents are undefined until written.
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/pp_txbuf_ctrl.sv
module pp_txbuf_ctrl
   import pp_txbuf_pkg::*;
#(
   parameter int unsigned PKT_BYTES = 64,
   localparam int unsigned AW       = $clog2(PKT_BYTES),
   localparam int unsigned LW       = $clog2(PKT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_valid_i,
   input  logic              commit_i,
   input  logic              rd_en_i,
   input  logic              ack_i,
   input  logic              retry_i,
   output logic [NBANKS-1:0] bank_we,
   output logic [AW-1:0]     wr_addr,
   output bank_t             rd_bank,
   output logic [AW-1:0]     rd_addr,
   output logic              wr_req_o,
   output logic              rd_ready_o,
   output logic [LW-1:0]     rd_len_o,
   output logic              ovf_o
);

   localparam logic [LW-1:0] PKT_LIM = LW'(PKT_BYTES);

   bank_t             fill_q, send_q;
   logic [NBANKS-1:0] full_q;
   logic [LW-1:0]     len_q [NBANKS];
   logic [LW-1:0]     wr_ptr_q, rd_ptr_q;
   logic              ovf_q;

   logic fill_open, send_busy;
   logic do_commit, do_write, do_drop;
   logic do_ack, do_retry, do_step;

   always_comb begin
      fill_open = ~full_q[fill_q];
      send_busy = full_q[send_q];
      do_commit = commit_i & fill_open;
      // A byte on the commit cycle is discarded.
      do_write  = wr_valid_i & fill_open & ~commit_i & (wr_ptr_q < PKT_LIM);
      do_drop   = wr_valid_i & fill_open & ~commit_i & (wr_ptr_q >= PKT_LIM);
      do_ack    = ack_i & send_busy;
      do_retry  = retry_i & send_busy & ~ack_i;
      do_step   = rd_en_i & send_busy & ~ack_i & ~retry_i
                  & (rd_ptr_q < len_q[send_q]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q   <= 1'b0;
         send_q   <= 1'b0;
         full_q   <= '0;
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         ovf_q    <= 1'b0;
         for (int b = 0; b < NBANKS; b++) len_q[b] <= '0;
      end else if (clear_i) begin
         fill_q   <= 1'b0;
         send_q   <= 1'b0;
         full_q   <= '0;
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         ovf_q    <= 1'b0;
         for (int b = 0; b < NBANKS; b++) len_q[b] <= '0;
      end else begin
         if (do_write) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_drop)  ovf_q    <= 1'b1;
         // Commit and ack never touch the same half: one needs it empty,
         // the other needs it full.
         if (do_commit) begin
            full_q[fill_q] <= 1'b1;
            len_q[fill_q]  <= wr_ptr_q;
            fill_q         <= other_bank(fill_q);
            wr_ptr_q       <= '0;
         end
         if (do_ack) begin
            full_q[send_q] <= 1'b0;
            send_q         <= other_bank(send_q);
            rd_ptr_q       <= '0;
         end else if (do_retry) begin
            rd_ptr_q <= '0;
         end else if (do_step) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
         end
      end
   end

   always_comb begin
      for (int b = 0; b < NBANKS; b++) begin
         bank_we[b] = do_write & (fill_q == bank_t'(b));
      end
   end

   assign wr_addr    = wr_ptr_q[AW-1:0];
   assign rd_addr    = rd_ptr_q[AW-1:0];
   assign rd_bank    = send_q;
   assign wr_req_o   = fill_open;
   assign rd_ready_o = send_busy;
   assign rd_len_o   = send_busy ? len_q[send_q] : '0;
   assign ovf_o      = ovf_q;

endmodule

// File: rtl/pp_tx_buffer.sv
module pp_tx_buffer
   import pp_txbuf_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PKT_BYTES = 64,
   localparam int unsigned AW       = $clog2(PKT_BYTES),
   localparam int unsigned LW       = $clog2(PKT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              commit_i,
   output logic              wr_req_o,
   output logic              ovf_o,
   output logic              rd_ready_o,
   output logic [LW-1:0]     rd_len_o,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              ack_i,
   input  logic              retry_i
);

   if (PKT_BYTES < 2) begin : g_bad_depth
      $error("pp_tx_buffer: PKT_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pp_tx_buffer: DATA_W must be at least 1");
   end

   logic [NBANKS-1:0] bank_we;
   logic [AW-1:0]     wr_addr, rd_addr;
   bank_t             rd_bank;
   logic [DATA_W-1:0] bank_rd [NBANKS];

   pp_txbuf_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear_i),
      .wr_valid_i (wr_valid_i),
      .commit_i   (commit_i),
      .rd_en_i    (rd_en_i),
      .ack_i      (ack_i),
      .retry_i    (retry_i),
      .bank_we    (bank_we),
      .wr_addr    (wr_addr),
      .rd_bank    (rd_bank),
      .rd_addr    (rd_addr),
      .wr_req_o   (wr_req_o),
      .rd_ready_o (rd_ready_o),
      .rd_len_o   (rd_len_o),
      .ovf_o      (ovf_o)
   );

   for (genvar g = 0; g < NBANKS; g++) begin : g_bank
      pp_txbuf_bank #(.DATA_W(DATA_W), .DEPTH(PKT_BYTES)) u_bank (
         .clk   (clk),
         .we    (bank_we[g]),
         .waddr (wr_addr),
         .wdata (wr_data_i),
         .raddr (rd_addr),
         .rdata (bank_rd[g])
      );
   end

   assign rd_data_o = bank_rd[rd_bank];

endmodule

// File: rtl/pp_txbuf_chk.sv
module pp_txbuf_chk #(
   parameter int unsigned PKT_BYTES = 64,
   localparam int unsigned LW       = $clog2(PKT_BYTES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clear_i,
   input logic          commit_i,
   input logic          ack_i,
   input logic          retry_i,
   input logic          wr_req_o,
   input logic          ovf_o,
   input logic          rd_ready_o,
   input logic [LW-1:0] rd_len_o
);

   p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (wr_req_o && !rd_ready_o && !ovf_o && rd_len_o == '0));

   p_commit_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && wr_req_o && !clear_i) |=> rd_ready_o);

   p_blocked_has_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req_o |-> rd_ready_o);

   p_blocked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_req_o && !ack_i && !clear_i) |=> (!wr_req_o && $stable(rd_len_o)));

   p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_len_o <= LW'(PKT_BYTES));

   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clear_i) |=> ovf_o);

   p_retry_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_i && !ack_i && rd_ready_o && !clear_i) |=> (rd_ready_o && $stable(rd_len_o)));

   p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !rd_ready_o && !commit_i && !clear_i) |=> !rd_ready_o);

endmodule

bind pp_tx_buffer pp_txbuf_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clear_i    (clear_i),
   .commit_i   (commit_i),
   .ack_i      (ack_i),
   .retry_i    (retry_i),
   .wr_req_o   (wr_req_o),
   .ovf_o      (ovf_o),
   .rd_ready_o (rd_ready_o),
   .rd_len_o   (rd_len_o)
);

// File: tb/pp_tx_buffer_tb.sv
module pp_tx_buffer_tb;

   localparam int PB = 64;
   localparam int LW = $clog2(PB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear_i = 1'b0, wr_valid_i = 1'b0, commit_i = 1'b0;
   logic [7:0]    wr_data_i = '0;
   logic          rd_en_i = 1'b0, ack_i = 1'b0, retry_i = 1'b0;
   logic          wr_req_o, ovf_o, rd_ready_o;
   logic [LW-1:0] rd_len_o;
   logic [7:0]    rd_data_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pp_tx_buffer #(.DATA_W(8), .PKT_BYTES(PB)) u_dut (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .commit_i(commit_i),
      .wr_req_o(wr_req_o), .ovf_o(ovf_o), .rd_ready_o(rd_ready_o),
      .rd_len_o(rd_len_o), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
      .ack_i(ack_i), .retry_i(retry_i)
   );

   // Reference model: pending packets as a length queue over one byte queue.
   int         lenq[$];
   logic [7:0] bytq[$];
   logic [7:0] cur[$];
   int         rdi;
   bit         m_ovf;
   int         m_n;

   always @(posedge clk) begin
      if (!rst_n || clear_i) begin
         lenq.delete(); bytq.delete(); cur.delete();
         rdi = 0; m_ovf = 0;
      end else begin
         m_n = lenq.size();
         if (m_n > 0) begin
            if (ack_i) begin
               for (int k = 0; k < lenq[0]; k++) void'(bytq.pop_front());
               void'(lenq.pop_front());
               rdi = 0;
            end else if (retry_i) rdi = 0;
            else if (rd_en_i && rdi < lenq[0]) rdi++;
         end
         if (m_n < 2) begin
            if (commit_i) begin
               foreach (cur[k]) bytq.push_back(cur[k]);
               lenq.push_back(cur.size());
               cur.delete();
            end else if (wr_valid_i) begin
               if (cur.size() < PB) cur.push_back(wr_data_i);
               else m_ovf = 1;
            end
         end
      end
   end

   task automatic ck(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare against the model on every falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         ck(wr_req_o === (lenq.size() < 2), "R5 wr_req", wr_req_o, lenq.size() < 2);
         ck(rd_ready_o === (lenq.size() > 0), "R6 ready", rd_ready_o, lenq.size() > 0);
         ck(rd_len_o === LW'(lenq.size() > 0 ? lenq[0] : 0), "R2 len", rd_len_o,
            lenq.size() > 0 ? lenq[0] : 0);
         ck(ovf_o === m_ovf, "R3 ovf", ovf_o, m_ovf);
         if (lenq.size() > 0 && rdi < lenq[0])
            ck(rd_data_o === bytq[rdi], "R7 data", rd_data_o, bytq[rdi]);
      end
   end

   task automatic tick(input bit wv, input logic [7:0] wd, input bit cm,
                       input bit re, input bit ak, input bit rt, input bit cl);
      @(negedge clk);
      wr_valid_i = wv; wr_data_i = wd; commit_i = cm;
      rd_en_i = re; ack_i = ak; retry_i = rt; clear_i = cl;
      @(posedge clk);
      #2;
      wr_valid_i = 0; commit_i = 0; rd_en_i = 0; ack_i = 0; retry_i = 0; clear_i = 0;
   endtask

   task automatic wr(input logic [7:0] d);  tick(1, d, 0, 0, 0, 0, 0); endtask
   task automatic commit();                 tick(0, 0, 1, 0, 0, 0, 0); endtask
   task automatic ack();                    tick(0, 0, 0, 0, 1, 0, 0); endtask
   task automatic rd();                     tick(0, 0, 0, 1, 0, 0, 0); endtask

   initial begin
      #1500000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tick(0, 0, 0, 0, 0, 0, 0);
      ck(wr_req_o && !rd_ready_o && !ovf_o && rd_len_o == 0, "R1 reset state",
         {wr_req_o, rd_ready_o, ovf_o}, 3'b100);

      for (int i = 0; i < 5; i++) wr(8'h10 + 8'(i));
      commit();
      ck(rd_ready_o && rd_len_o == 5, "R2 len after commit", rd_len_o, 5);
      ck(wr_req_o == 1'b1, "R4 second half open", wr_req_o, 1);
      for (int i = 0; i < 3; i++) wr(8'h20 + 8'(i));
      commit();
      ck(wr_req_o == 1'b0, "R5 both halves full", wr_req_o, 0);
      wr(8'h99);
      commit();
      ck(!wr_req_o && rd_len_o == 5, "R5 write/commit ignored", rd_len_o, 5);
      ck(rd_data_o == 8'h10, "R7 first byte", rd_data_o, 8'h10);
      rd();
      ck(rd_data_o == 8'h11, "R7 second byte", rd_data_o, 8'h11);
      for (int i = 0; i < 6; i++) rd();
      tick(0, 0, 0, 0, 0, 1, 0);
      ck(rd_data_o == 8'h10 && rd_len_o == 5, "R9 retry rewinds", rd_data_o, 8'h10);
      ack();
      ck(rd_len_o == 3 && rd_data_o == 8'h20, "R6 commit order", rd_len_o, 3);
      ck(wr_req_o == 1'b1, "R8 ack frees half", wr_req_o, 1);
      commit();
      ack();
      ck(rd_ready_o && rd_len_o == 0, "R2 zero-length packet", rd_len_o, 0);
      ack();
      ck(!rd_ready_o, "R8 last packet freed", rd_ready_o, 0);
      ack();
      ck(!rd_ready_o && wr_req_o, "R8 idle ack ignored", rd_ready_o, 0);

      for (int i = 0; i < PB + 6; i++) wr(8'(i));
      ck(ovf_o == 1'b1, "R3 overflow flag", ovf_o, 1);
      commit();
      ck(rd_len_o == LW'(PB), "R3 length capped", rd_len_o, PB);
      ack();
      ck(ovf_o == 1'b1, "R3 overflow sticky", ovf_o, 1);

      wr(8'hA0); wr(8'hA1);
      tick(1, 8'hA2, 1, 0, 0, 0, 0);
      ck(rd_len_o == 2, "R11 commit-cycle byte dropped", rd_len_o, 2);
      ack();

      wr(8'hB0); commit(); wr(8'hC0); wr(8'hC1); commit();
      tick(0, 0, 0, 0, 1, 1, 0);
      ck(rd_len_o == 2 && rd_data_o == 8'hC0, "R8 ack beats retry", rd_len_o, 2);
      wr(8'hD0); commit();
      tick(0, 0, 0, 0, 0, 0, 1);
      ck(!rd_ready_o && wr_req_o && !ovf_o && rd_len_o == 0, "R10 clear discards",
         {rd_ready_o, wr_req_o, ovf_o}, 3'b010);
      wr(8'hE0); commit();
      ck(rd_len_o == 1 && rd_data_o == 8'hE0, "R10 fresh after clear", rd_len_o, 1);

      for (int i = 0; i < 4000; i++) begin
         tick(($urandom % 2) == 0, 8'($urandom), ($urandom % 16) == 0,
              ($urandom % 2) == 0, ($urandom % 12) == 0, ($urandom % 30) == 0,
              ($urandom % 150) == 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule